// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and a byte-wide asynchronous static RAM with a 20-bit address and an 8-bit bidirectional data bus. The host raises a request for a single clock cycle, either a read or a write. The controller then produces the chip-select pair, output-enable and write-enable strobes for the memory. Each interval is held for a whole number of clock cycles, chosen so that the memory's minimum access, setup, pulse and recovery times are met. All strobes come from flops, so they do not glitch. The controller drives the shared data bus only while a write needs it.

The memory is selected only when its active-low enable is low and its active-high enable is high. Every idle and standby state drives both enables to their inactive levels. A write keeps output-enable high from start to finish. The memory therefore never drives the bus during a write, and the write pulse does not need to cover bus turnaround. While a level-sensitive standby request is held, the memory stays deselected so that its supply can be lowered. When the request is released, the controller waits one full read-cycle time before it accepts another access.

Read data is captured on the last cycle of the access and is shown to the host with a one-cycle valid pulse. Every interval is a parameter given in nanoseconds. It is turned into a cycle count by dividing by the clock period and rounding up, with a floor of one cycle.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is high, and after it, the controller is idle with both enables inactive (active-low enable = 1, active-high enable = 0), output-enable = 1, write-enable = 1, busy = 0, read-valid = 0, and the data bus not driven.
- R2: An accepted read selects the memory with output-enable low and write-enable high for exactly ceil(T_RC_NS/CLK_NS) cycles. The byte on the bus in the last cycle is then shown on rd_data with rd_valid high for one cycle, which is ceil(T_RC_NS/CLK_NS)+1 falling edges after the request was presented.
- R3: An accepted write selects the memory with write-enable high for ceil(T_AS_NS/CLK_NS) cycles, then holds write-enable low for ceil(T_WP_NS/CLK_NS) cycles, with output-enable high throughout.
- R4: The controller drives the data bus with the request's write byte only from the first write-enable-low cycle through the first cycle after write-enable rises. The byte held when write-enable rises is what the memory stores.
- R5: The memory address changes only while the memory is deselected.
- R6: busy is high in every state except idle. A request presented while busy is high has no effect: no strobe activity, no stored data and no read-valid pulse.
- R7: When sleep_req is high in idle, the memory is deselected (active-low enable = 1, active-high enable = 0) and busy stays high for as long as sleep_req stays high. Requests made in this time are ignored.
- R8: After sleep_req falls, busy stays high for exactly ceil(T_RC_NS/CLK_NS) more cycles before the next request can be accepted.
- R9: If sleep_req and a request arrive together in idle, standby wins and the request is dropped.
- R10: Each interval count is the nanosecond parameter divided by the clock period and rounded up, and is never less than one cycle. This applies to zero-length setup and recovery times too, which the write recovery shows as exactly ceil(T_WR_NS/CLK_NS) selected cycles after write-enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Single-cycle access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Access address |
| req_wdata | input | 8 | Write byte |
| sleep_req | input | 1 | Level request for standby/retention |
| busy | output | 1 | High whenever the controller is not idle |
| rd_valid | output | 1 | One-cycle pulse marking rd_data valid |
| rd_data | output | 8 | Captured read byte |
| mem_addr | output | 20 | Memory address |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq | inout | 8 | Bidirectional memory data bus |

## Verification
The bench builds the controller with a 20 ns clock, a 55 ns read cycle, a 45 ns write pulse, a 25 ns address setup and a 0 ns write recovery. These give counts of 3, 3, 2 and 1 cycles. With these values, the bench sees rounding up on a non-multiple (55 ns gives 3 cycles), a setup phase longer than one cycle, and the one-cycle floor on a zero interval. The read-cycle count of 3 also fixes the post-standby wait, so the resume delay can be told apart from the single idle cycle.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_DONE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER,
        ST_STANDBY,
        ST_RESUME_WAIT
    } ctl_state_t;

    // Memory strobe set, all registered together
    typedef struct packed {
        logic sel_n;   // active-low chip enable
        logic sel_hi;  // active-high chip enable
        logic rd_n;    // output enable, active low
        logic wr_n;    // write enable, active low
    } strobe_t;

    localparam strobe_t STROBE_OFF = '{sel_n: 1'b1, sel_hi: 1'b0, rd_n: 1'b1, wr_n: 1'b1};

    // Interval in ns -> whole clock cycles, rounded up, floor of one
    function automatic int ns_to_cycles(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    // Strobe pattern wanted while in a given state
    function automatic strobe_t strobe_for(input ctl_state_t s);
        strobe_t v;
        v = STROBE_OFF;
        case (s)
            ST_RD_ACCESS: v = '{sel_n: 1'b0, sel_hi: 1'b1, rd_n: 1'b0, wr_n: 1'b1};
            ST_WR_SETUP,
            ST_WR_RECOVER: v = '{sel_n: 1'b0, sel_hi: 1'b1, rd_n: 1'b1, wr_n: 1'b1};
            ST_WR_PULSE:  v = '{sel_n: 1'b0, sel_hi: 1'b1, rd_n: 1'b1, wr_n: 1'b0};
            default:      v = STROBE_OFF;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/asram_timer.sv
`timescale 1ns/1ps
module asram_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/asram_fsm.sv
`timescale 1ns/1ps
module asram_fsm
    import asram_pkg::*;
#(
    parameter int RC_CYC = 3,
    parameter int AS_CYC = 1,
    parameter int WP_CYC = 3,
    parameter int WR_CYC = 1,
    parameter int CW     = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          sleep_req,
    input  logic          tmr_done,
    output ctl_state_t    state_q,
    output ctl_state_t    state_n,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          accept,
    output logic          capture
);
    localparam logic [CW-1:0] RC_LD = CW'(RC_CYC - 1);
    localparam logic [CW-1:0] AS_LD = CW'(AS_CYC - 1);
    localparam logic [CW-1:0] WP_LD = CW'(WP_CYC - 1);
    localparam logic [CW-1:0] WR_LD = CW'(WR_CYC - 1);

    assign accept  = (state_q == ST_IDLE) && req_valid && !sleep_req;
    assign capture = (state_q == ST_RD_ACCESS) && tmr_done;

    always_comb begin
        state_n  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state_q)
            ST_IDLE: begin
                if (sleep_req) begin
                    state_n = ST_STANDBY;
                end else if (req_valid) begin
                    tmr_load = 1'b1;
                    if (req_write) begin
                        state_n = ST_WR_SETUP;
                        tmr_val = AS_LD;
                    end else begin
                        state_n = ST_RD_ACCESS;
                        tmr_val = RC_LD;
                    end
                end
            end
            ST_RD_ACCESS: if (tmr_done) state_n = ST_RD_DONE;
            ST_RD_DONE:   state_n = ST_IDLE;
            ST_WR_SETUP: if (tmr_done) begin
                state_n  = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = WP_LD;
            end
            ST_WR_PULSE: if (tmr_done) begin
                state_n  = ST_WR_RECOVER;
                tmr_load = 1'b1;
                tmr_val  = WR_LD;
            end
            ST_WR_RECOVER: if (tmr_done) state_n = ST_IDLE;
            ST_STANDBY: if (!sleep_req) begin
                state_n  = ST_RESUME_WAIT;
                tmr_load = 1'b1;
                tmr_val  = RC_LD;
            end
            ST_RESUME_WAIT: if (tmr_done) state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_n;
    end

    // R8: leaving the resume wait always lands in idle
    a_r8_resume_to_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RESUME_WAIT && tmr_done) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/asram_io.sv
`timescale 1ns/1ps
module asram_io
    import asram_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  ctl_state_t        state_q,
    input  ctl_state_t        state_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output strobe_t           strobes,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            strobes  <= STROBE_OFF;
            addr_q   <= '0;
            dq_out   <= '0;
            dq_oe    <= 1'b0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            strobes  <= strobe_for(state_n);
            // Drivers on for the pulse and one cycle past it (data hold)
            dq_oe    <= (state_n == ST_WR_PULSE) || (state_q == ST_WR_PULSE);
            rd_valid <= capture;
            if (accept) begin
                addr_q <= req_addr;
                dq_out <= req_wdata;
            end
            if (capture)
                rd_data <= dq_in;
        end
    end

    // R4: the controller never drives while the memory may be driving
    a_r4_no_contention: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> strobes.rd_n);
    // R2: read-valid is a single-cycle pulse
    a_r2_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);
endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int DATA_W  = 8,
    parameter int CLK_NS  = 20,
    parameter int T_RC_NS = 55,
    parameter int T_WP_NS = 45,
    parameter int T_AS_NS = 0,
    parameter int T_WR_NS = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              sleep_req,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    inout  wire  [DATA_W-1:0] mem_dq
);
    localparam int RC_CYC = ns_to_cycles(T_RC_NS, CLK_NS);
    localparam int WP_CYC = ns_to_cycles(T_WP_NS, CLK_NS);
    localparam int AS_CYC = ns_to_cycles(T_AS_NS, CLK_NS);
    localparam int WR_CYC = ns_to_cycles(T_WR_NS, CLK_NS);
    localparam int CW     = $clog2(RC_CYC + WP_CYC + AS_CYC + WR_CYC + 1);

    ctl_state_t        state_q, state_n;
    logic              tmr_load, tmr_done, accept, capture, dq_oe;
    logic [CW-1:0]     tmr_val;
    logic [DATA_W-1:0] dq_out;
    strobe_t           strobes;

    asram_fsm #(
        .RC_CYC(RC_CYC), .AS_CYC(AS_CYC), .WP_CYC(WP_CYC), .WR_CYC(WR_CYC), .CW(CW)
    ) u_fsm (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .sleep_req(sleep_req), .tmr_done(tmr_done), .state_q(state_q),
        .state_n(state_n), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .accept(accept), .capture(capture)
    );

    asram_timer #(.W(CW)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    asram_io #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
        .clk(clk), .rst(rst), .accept(accept), .req_addr(req_addr),
        .req_wdata(req_wdata), .state_q(state_q), .state_n(state_n),
        .capture(capture), .dq_in(mem_dq), .strobes(strobes), .addr_q(mem_addr),
        .dq_out(dq_out), .dq_oe(dq_oe), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    assign mem_dq   = dq_oe ? dq_out : {DATA_W{1'bz}};
    assign mem_ce_n = strobes.sel_n;
    assign mem_ce2  = strobes.sel_hi;
    assign mem_oe_n = strobes.rd_n;
    assign mem_we_n = strobes.wr_n;
    assign busy     = (state_q != ST_IDLE);

    logic selected;
    assign selected = !mem_ce_n && mem_ce2;

    // R3: output enable stays high whenever write enable is low
    a_r3_oe_high_in_write: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n);
    // R3: a write pulse only happens with the chip selected
    a_r3_we_needs_select: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> selected);
    // R5: address holds while the chip stays selected
    a_r5_addr_stable: assert property (@(posedge clk) disable iff (rst)
        selected |=> (!selected || $stable(mem_addr)));
    // R7: standby keeps the chip deselected
    a_r7_standby_deselect: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STANDBY) |-> (mem_ce_n && !mem_ce2));
    // R6: no accepted request while busy
    a_r6_idle_accept: assert property (@(posedge clk) disable iff (rst)
        busy |=> !$rose(selected) || $past(state_q == ST_IDLE));
endmodule

// File: tb/asram_ctrl_tb_top.sv
`timescale 1ns/1ps
module asram_ctrl_tb_top;
    localparam int CLK_NS = 20;
    localparam int RC = 3;   // 55 ns / 20 ns rounded up
    localparam int WP = 3;   // 45 ns
    localparam int AS = 2;   // 25 ns
    localparam int WR = 1;   // 0 ns -> floor of one

    logic        clk = 1'b0, rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, sleep_req = 1'b0;
    logic [19:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, rd_valid, mem_ce_n, mem_ce2, mem_oe_n, mem_we_n;
    logic [7:0]  rd_data;
    logic [19:0] mem_addr;
    wire  [7:0]  mem_dq;

    always #(CLK_NS/2) clk = ~clk;

    asram_ctrl #(.CLK_NS(CLK_NS), .T_RC_NS(55), .T_WP_NS(45), .T_AS_NS(25), .T_WR_NS(0)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .sleep_req(sleep_req),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq(mem_dq)
    );

    // Behavioural memory
    logic [7:0] mdl [int];
    logic [7:0] mdl_q;
    logic       mdl_drv;
    assign mem_dq = mdl_drv ? mdl_q : 8'bz;
    always @(mem_addr, mem_ce_n, mem_ce2, mem_oe_n, mem_we_n) begin
        mdl_drv = (mem_ce_n === 1'b0) && (mem_ce2 === 1'b1) && (mem_oe_n === 1'b0) && (mem_we_n === 1'b1);
        mdl_q   = mdl.exists(int'(mem_addr)) ? mdl[int'(mem_addr)] : 8'h00;
    end
    always @(posedge mem_we_n)
        if (!rst && mem_ce_n === 1'b0 && mem_ce2 === 1'b1)
            mdl[int'(mem_addr)] = mem_dq;

    int checks = 0, fails = 0, cyc = 0;
    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Scoreboard
    logic [7:0] shadow [int];
    logic [7:0] exp_q [$];
    int         start_q [$];
    logic [7:0] cur_wdata = '0;

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic do_write(input logic [19:0] a, input logic [7:0] d);
        wait_idle();
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        cur_wdata = d;
        shadow[int'(a)] = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_read(input logic [19:0] a);
        wait_idle();
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
        start_q.push_back(cyc);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor
    int oe_cnt = 0, we_cnt = 0, su_cnt = 0, rec_cnt = 0;
    bit in_rec = 0, prev_sel = 0;
    logic [19:0] prev_addr = '0;
    always @(negedge clk) begin
        if (!rst) begin
            automatic bit sel = (mem_ce_n == 1'b0) && (mem_ce2 == 1'b1);
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected read-valid", int'(rd_data), 0);
                end else begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    automatic int s = start_q.pop_front();
                    chk(rd_data == e, "R2 read data", int'(rd_data), int'(e));
                    chk(cyc - s == RC + 1, "R2 read latency", cyc - s, RC + 1);
                end
            end
            if (!mem_oe_n) oe_cnt++;
            else if (oe_cnt != 0) begin
                chk(oe_cnt == RC, "R2 output-enable length", oe_cnt, RC);
                oe_cnt = 0;
            end
            if (in_rec) begin
                if (sel) rec_cnt++;
                else begin
                    chk(rec_cnt == WR, "R10 recovery length", rec_cnt, WR);
                    in_rec = 0;
                end
            end
            if (!mem_we_n) begin
                if (we_cnt == 0) chk(su_cnt == AS, "R3 setup length", su_cnt, AS);
                we_cnt++;
                chk(mem_dq === cur_wdata, "R4 driven data", int'(mem_dq), int'(cur_wdata));
                chk(mem_oe_n == 1'b1, "R3 output-enable high", int'(mem_oe_n), 1);
            end else if (we_cnt != 0) begin
                chk(we_cnt == WP, "R3 pulse length", we_cnt, WP);
                chk(mem_dq === cur_wdata, "R4 data hold", int'(mem_dq), int'(cur_wdata));
                we_cnt = 0; in_rec = 1; rec_cnt = 1;
            end
            if (!sel) su_cnt = 0;
            else if (mem_we_n && we_cnt == 0 && !in_rec) su_cnt++;
            if (sel && prev_sel)
                chk(mem_addr == prev_addr, "R5 address stable", int'(mem_addr), int'(prev_addr));
            prev_sel = sel; prev_addr = mem_addr;
        end
    end

    initial begin
        #(CLK_NS * 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mem_ce_n == 1'b1 && mem_ce2 == 1'b0, "R1 enables idle", {mem_ce_n, mem_ce2}, 2);
        chk(mem_oe_n == 1'b1 && mem_we_n == 1'b1, "R1 oe/we high", {mem_oe_n, mem_we_n}, 3);
        chk(busy == 1'b0 && rd_valid == 1'b0, "R1 busy/valid low", {busy, rd_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && mem_ce_n == 1'b1, "R1 idle after reset", {busy, mem_ce_n}, 1);

        // R2/R3/R4: writes and read-backs at address extremes
        do_write(20'h00000, 8'h3C);
        do_write(20'hFFFFF, 8'hC3);
        do_write(20'h5A5A5, 8'h81);
        do_read(20'h00000);
        do_read(20'hFFFFF);
        do_read(20'h5A5A5);
        do_read(20'h12345);          // never written
        do_write(20'h0F0F0, 8'hFF);
        do_read(20'h0F0F0);
        do_write(20'h0F0F0, 8'h00);
        do_read(20'h0F0F0);

        // R6: write request while a read is in flight is dropped
        do_read(20'h5A5A5);
        chk(busy == 1'b1, "R6 busy during read", int'(busy), 1);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h5A5A5; req_wdata = 8'h55;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        @(negedge clk);
        chk(mem_we_n == 1'b1 && mem_ce_n == 1'b1, "R6 no strobe after drop", {mem_we_n, mem_ce_n}, 3);
        do_read(20'h5A5A5);          // still 0x81

        // R7: standby deselects and ignores requests
        wait_idle();
        sleep_req = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            req_valid = 1'b1; req_write = (i % 2 == 0); req_addr = 20'h00000; req_wdata = 8'hEE;
            chk(mem_ce_n == 1'b1 && mem_ce2 == 1'b0, "R7 deselected", {mem_ce_n, mem_ce2}, 2);
            chk(busy == 1'b1, "R7 busy in standby", int'(busy), 1);
            @(negedge clk);
        end
        req_valid = 1'b0;
        sleep_req = 1'b0;
        // R8: resume wait of one read cycle
        begin
            int n = 0;
            @(negedge clk);
            while (busy) begin n++; @(negedge clk); end
            chk(n == RC, "R8 resume wait", n, RC);
        end
        do_read(20'h00000);          // still 0x3C, standby request ignored

        // R9: simultaneous sleep and request
        wait_idle();
        sleep_req = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_addr = 20'hFFFFF; req_wdata = 8'h99;
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_ce_n == 1'b1 && mem_ce2 == 1'b0, "R9 standby wins", {mem_ce_n, mem_ce2}, 2);
        repeat (2) @(negedge clk);
        sleep_req = 1'b0;
        do_read(20'hFFFFF);          // still 0xC3

        wait_idle();
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all reads returned", exp_q.size(), 0);
        report();
    end
endmodule